// File: doc/BRIEF.md
# Priority-Routing System Interrupt Controller

This block gathers a set of peripheral interrupt lines, organised as banks of 32, and steers each line to one of several core priority levels. Every source has its own 4-bit routing field. The field selects the level the source drives, or parks the source so that it drives nothing. A per-bit mask gates each source before routing. A separate per-bit wake-enable register lets chosen sources raise a single wake output whatever their mask holds.

Software uses a word-addressed register port. Through it, it reads the live source lines and reads and writes the mask, wake-enable and routing registers. For every level the core sees a request bit and the number of the lowest-numbered source behind that request. The core's handler for the level can then service that source first. All outputs are registered, so they follow the inputs and register contents with one clock of latency.

Top module: `sysirq_router`

## Requirements
- R1: After reset, lvl_req and wake_out are 0 and every lvl_src slot is 0. Every mask and wake-enable bit reads 0. Each routing field holds a default: source n gets n mod 7.
- R2: Word addresses are as follows. 0x00+b holds the status of bank b. 0x08+b holds the mask of bank b. 0x10+b holds the wake enables of bank b. 0x20+k is routing word k, which holds sources 8k to 8k+7, with source n at bits (n mod 8)*4 to (n mod 8)*4+3. Source s lives in bank s/32 at bit s mod 32. Any unmapped address reads 0.
- R3: A status word reads the live irq_in bits of its bank with no latching. A write to a status address changes no register.
- R4: A source is pending only when its irq_in bit and its mask bit are both 1. A source whose mask bit is 0 never raises a level request.
- R5: A pending source whose routing field holds v, with v below NUM_LEVELS, sets lvl_req bit v. Bit v stands for core level 7+v.
- R6: A pending source whose routing field is NUM_LEVELS or above (7 to 15 by default) raises no lvl_req bit.
- R7: lvl_src slot v (bits v*7 to v*7+6) gives the lowest-numbered pending source routed to level v. The slot is 0 when that level has nothing pending.
- R8: wake_out is 1 when any source has both its irq_in bit and its wake-enable bit at 1. The mask has no effect on it.
- R9: lvl_req, lvl_src and wake_out change on the first clock edge after the inputs or registers they depend on change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Live peripheral request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| lvl_req | output | NUM_LEVELS | Request per core level (bit v = level 7+v) |
| lvl_src | output | NUM_LEVELS*7 | Lowest pending source number per level |
| wake_out | output | 1 | Wake request |

## Verification
The assertions assume that irq_in and the bus inputs change only between clock edges, and that reset is held for at least one edge before release. The stimulus satisfies this by driving every input on the falling edge. Register writes last exactly one cycle, and reset is held low for several cycles from time zero. The property linking a request to a pending source expects no level to raise a request after a cycle in which nothing was pending. The bench therefore sweeps every source against every routing value with only that one source active, and separately applies random full-width patterns of sources, masks and routing words.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;

  localparam int WORD_W          = 32;
  localparam int FIELD_W         = 4;
  localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
  localparam int ADDR_W          = 6;

  typedef enum logic [2:0] {
    RG_STATUS,
    RG_MASK,
    RG_WAKE,
    RG_ROUTE,
    RG_NONE
  } region_e;

  // Upper address bit selects the routing words; bits [4:3] select the bank groups.
  function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
    region_e r;
    if (a[5]) begin
      r = RG_ROUTE;
    end else begin
      unique case (a[4:3])
        2'd0:    r = RG_STATUS;
        2'd1:    r = RG_MASK;
        2'd2:    r = RG_WAKE;
        default: r = RG_NONE;
      endcase
    end
    return r;
  endfunction

  // Routing field of one slot inside a packed routing word.
  function automatic logic [FIELD_W-1:0] field_at(input logic [WORD_W-1:0] w,
                                                  input int unsigned slot);
    return w[slot*FIELD_W +: FIELD_W];
  endfunction

  // Reset routing word: each source n gets level n mod levels.
  function automatic logic [WORD_W-1:0] default_route(input int unsigned idx,
                                                      input int unsigned levels);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int unsigned slot = 0; slot < FIELDS_PER_WORD; slot++) begin
      w[slot*FIELD_W +: FIELD_W] = FIELD_W'((idx*FIELDS_PER_WORD + slot) % levels);
    end
    return w;
  endfunction

endpackage

// File: rtl/sysirq_regs.sv
module sysirq_regs
  import sysirq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int NUM_LEVELS = 7
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_BANKS*WORD_W-1:0]           irq_in,
  input  logic                                  bus_wr,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [WORD_W-1:0]                     bus_wdata,
  output logic [WORD_W-1:0]                     bus_rdata,
  output logic [NUM_BANKS*WORD_W-1:0]           mask_flat,
  output logic [NUM_BANKS*WORD_W-1:0]           wake_flat,
  output logic [NUM_BANKS*WORD_W*FIELD_W-1:0]   asg_flat,
  output logic                                  status_wr
);

  localparam int NSRC = NUM_BANKS * WORD_W;
  localparam int NASG = NSRC / FIELDS_PER_WORD;

  region_e           rgn;
  logic [WORD_W-1:0] mask_q [NUM_BANKS];
  logic [WORD_W-1:0] wake_q [NUM_BANKS];
  logic [WORD_W-1:0] asg_q  [NASG];

  assign rgn       = decode_region(bus_addr);
  assign status_wr = bus_wr && (rgn == RG_STATUS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[b] <= '0;
        wake_q[b] <= '0;
      end else if (bus_wr && (bus_addr[2:0] == 3'(b))) begin
        if (rgn == RG_MASK) mask_q[b] <= bus_wdata;
        if (rgn == RG_WAKE) wake_q[b] <= bus_wdata;
      end
    end
    assign mask_flat[b*WORD_W +: WORD_W] = mask_q[b];
    assign wake_flat[b*WORD_W +: WORD_W] = wake_q[b];
  end

  for (genvar k = 0; k < NASG; k++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        asg_q[k] <= default_route(k, NUM_LEVELS);
      end else if (bus_wr && (rgn == RG_ROUTE) && (bus_addr[4:0] == 5'(k))) begin
        asg_q[k] <= bus_wdata;
      end
    end
    assign asg_flat[k*WORD_W +: WORD_W] = asg_q[k];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (rgn)
      RG_STATUS: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bus_addr[2:0] == 3'(b)) bus_rdata = irq_in[b*WORD_W +: WORD_W];
        end
      end
      RG_MASK: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bus_addr[2:0] == 3'(b)) bus_rdata = mask_q[b];
        end
      end
      RG_WAKE: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bus_addr[2:0] == 3'(b)) bus_rdata = wake_q[b];
        end
      end
      RG_ROUTE: begin
        for (int k = 0; k < NASG; k++) begin
          if (bus_addr[4:0] == 5'(k)) bus_rdata = asg_q[k];
        end
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sysirq_route.sv
module sysirq_route
  import sysirq_pkg::*;
#(
  parameter int NSRC       = 96,
  parameter int NUM_LEVELS = 7
) (
  input  logic [NSRC-1:0]                   irq_in,
  input  logic [NSRC-1:0]                   mask_flat,
  input  logic [NSRC*FIELD_W-1:0]           asg_flat,
  output logic [NSRC-1:0]                   pend_vec,
  output logic [NUM_LEVELS-1:0][NSRC-1:0]   lvl_hits
);

  assign pend_vec = irq_in & mask_flat;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [FIELD_W-1:0] fld;
    assign fld = field_at(asg_flat[(s/FIELDS_PER_WORD)*WORD_W +: WORD_W],
                          s % FIELDS_PER_WORD);
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
      assign lvl_hits[l][s] = pend_vec[s] && (fld == FIELD_W'(l));
    end
  end

endmodule

// File: rtl/sysirq_pick.sv
module sysirq_pick #(
  parameter int NSRC  = 96,
  parameter int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  vec,
  output logic             found,
  output logic [SRC_W-1:0] idx
);

  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (vec[i]) idx = SRC_W'(i);
    end
  end

  assign found = |vec;

endmodule

// File: rtl/sysirq_router.sv
module sysirq_router
  import sysirq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int NUM_LEVELS = 7
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic [NUM_BANKS*WORD_W-1:0]                         irq_in,
  input  logic                                                bus_wr,
  input  logic [ADDR_W-1:0]                                   bus_addr,
  input  logic [WORD_W-1:0]                                   bus_wdata,
  output logic [WORD_W-1:0]                                   bus_rdata,
  output logic [NUM_LEVELS-1:0]                               lvl_req,
  output logic [NUM_LEVELS*$clog2(NUM_BANKS*WORD_W)-1:0]      lvl_src,
  output logic                                                wake_out
);

  localparam int NSRC  = NUM_BANKS * WORD_W;
  localparam int SRC_W = $clog2(NSRC);

  logic [NSRC-1:0]                 mask_flat;
  logic [NSRC-1:0]                 wake_flat;
  logic [NSRC*FIELD_W-1:0]         asg_flat;
  logic                            status_wr;
  logic [NSRC-1:0]                 pend_vec;
  logic [NUM_LEVELS-1:0][NSRC-1:0] lvl_hits;
  logic [NUM_LEVELS-1:0]           lvl_any;
  logic [SRC_W-1:0]                lvl_idx [NUM_LEVELS];
  logic                            wake_hit;

  sysirq_regs #(
    .NUM_BANKS  (NUM_BANKS),
    .NUM_LEVELS (NUM_LEVELS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mask_flat (mask_flat),
    .wake_flat (wake_flat),
    .asg_flat  (asg_flat),
    .status_wr (status_wr)
  );

  sysirq_route #(
    .NSRC       (NSRC),
    .NUM_LEVELS (NUM_LEVELS)
  ) u_route (
    .irq_in    (irq_in),
    .mask_flat (mask_flat),
    .asg_flat  (asg_flat),
    .pend_vec  (pend_vec),
    .lvl_hits  (lvl_hits)
  );

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_pick
    sysirq_pick #(
      .NSRC  (NSRC),
      .SRC_W (SRC_W)
    ) u_pick (
      .vec   (lvl_hits[l]),
      .found (lvl_any[l]),
      .idx   (lvl_idx[l])
    );
  end

  assign wake_hit = |(irq_in & wake_flat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_req  <= '0;
      lvl_src  <= '0;
      wake_out <= 1'b0;
    end else begin
      lvl_req  <= lvl_any;
      for (int l = 0; l < NUM_LEVELS; l++) begin
        lvl_src[l*SRC_W +: SRC_W] <= lvl_idx[l];
      end
      wake_out <= wake_hit;
    end
  end

endmodule

// File: rtl/sysirq_chk.sv
module sysirq_chk #(
  parameter int NSRC       = 96,
  parameter int NUM_LEVELS = 7,
  parameter int ASG_W      = 384
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LEVELS-1:0] lvl_req,
  input logic                  wake_out,
  input logic [NSRC-1:0]       irq_in,
  input logic [NSRC-1:0]       pend_vec,
  input logic [NSRC-1:0]       mask_flat,
  input logic [NSRC-1:0]       wake_flat,
  input logic [ASG_W-1:0]      asg_flat,
  input logic                  status_wr
);

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(|mask_flat)) |-> (lvl_req == '0));

  // R9
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_req) |-> $past(|pend_vec));

  // R8
  wake_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_out |-> $past(|(irq_in & wake_flat)));

  // R3
  status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> ($stable(mask_flat) && $stable(wake_flat) && $stable(asg_flat)));

endmodule

bind sysirq_router sysirq_chk #(
  .NSRC       (NUM_BANKS*32),
  .NUM_LEVELS (NUM_LEVELS),
  .ASG_W      (NUM_BANKS*32*4)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lvl_req   (lvl_req),
  .wake_out  (wake_out),
  .irq_in    (irq_in),
  .pend_vec  (pend_vec),
  .mask_flat (mask_flat),
  .wake_flat (wake_flat),
  .asg_flat  (asg_flat),
  .status_wr (status_wr)
);

// File: tb/sysirq_router_tb.sv
module sysirq_router_tb;

  localparam int NB = 3;
  localparam int NS = NB * 32;
  localparam int NL = 7;
  localparam int SW = 7;
  localparam int NA = NS / 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NS-1:0]     irq_in;
  logic              bus_wr;
  logic [5:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NL-1:0]     lvl_req;
  logic [NL*SW-1:0]  lvl_src;
  logic              wake_out;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] mask_m [NB];
  logic [31:0] wake_m [NB];
  logic [31:0] asg_m  [NA];

  always #5 clk = ~clk;

  sysirq_router #(.NUM_BANKS(NB), .NUM_LEVELS(NL)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lvl_req   (lvl_req),
    .lvl_src   (lvl_src),
    .wake_out  (wake_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int field_of(input int s);
    return int'((asg_m[s/8] >> ((s % 8) * 4)) & 32'hF);
  endfunction

  function automatic bit is_pend(input logic [NS-1:0] irq, input int s);
    return irq[s] && mask_m[s/32][s%32];
  endfunction

  task automatic check_outs(input string req, input logic [NS-1:0] irq);
    logic [NL-1:0] e_req;
    int            e_src [NL];
    bit            e_wake;
    e_req  = '0;
    e_wake = 1'b0;
    for (int l = 0; l < NL; l++) e_src[l] = 0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (is_pend(irq, s) && field_of(s) < NL) begin
        e_req[field_of(s)] = 1'b1;
        e_src[field_of(s)] = s;
      end
      if (irq[s] && wake_m[s/32][s%32]) e_wake = 1'b1;
    end
    chk(req, "lvl_req", 32'(lvl_req), 32'(e_req));
    for (int l = 0; l < NL; l++) begin
      chk(req, $sformatf("lvl_src[%0d]", l), 32'(lvl_src[l*SW +: SW]), 32'(e_src[l]));
    end
    chk(req, "wake_out", 32'(wake_out), 32'(e_wake));
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    if (a >= 6'h20 && int'(a) - 32 < NA) asg_m[int'(a) - 32] = d;
    else if (a >= 6'h08 && int'(a) < 8 + NB) mask_m[int'(a) - 8] = d;
    else if (a >= 6'h10 && int'(a) < 16 + NB) wake_m[int'(a) - 16] = d;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0]   d;
    logic [NS-1:0] prev_irq;
    rst_n     = 1'b0;
    irq_in    = '0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int b = 0; b < NB; b++) begin
      mask_m[b] = '0;
      wake_m[b] = '0;
    end
    for (int k = 0; k < NA; k++) begin
      asg_m[k] = '0;
      for (int slot = 0; slot < 8; slot++) asg_m[k] |= 32'(((k * 8 + slot) % 7) << (slot * 4));
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_outs("R1", irq_in);
    for (int b = 0; b < NB; b++) begin
      rd(6'(8 + b), d);  chk("R1", "mask reset", d, 32'h0);
      rd(6'(16 + b), d); chk("R1", "wake reset", d, 32'h0);
    end
    for (int k = 0; k < NA; k++) begin
      rd(6'(32 + k), d); chk("R1", $sformatf("route word %0d reset", k), d, asg_m[k]);
    end

    // R2 unmapped addresses and register readback
    rd(6'h18, d); chk("R2", "unmapped 0x18", d, 32'h0);
    rd(6'(NB), d); chk("R2", "missing status bank", d, 32'h0);
    rd(6'(32 + NA), d); chk("R2", "missing route word", d, 32'h0);
    wr(6'h09, 32'hA5C3_0F11);
    rd(6'h09, d); chk("R2", "mask bank1 readback", d, 32'hA5C3_0F11);
    wr(6'h09, 32'h0);

    // R3 live status, status writes inert
    for (int it = 0; it < 8; it++) begin
      irq_in = {$urandom, $urandom, $urandom};
      for (int b = 0; b < NB; b++) begin
        rd(6'(b), d); chk("R3", "status live", d, irq_in[b*32 +: 32]);
      end
    end
    wr(6'h01, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(6'h09, d); chk("R3", "mask after status write", d, 32'h0);
    rd(6'h11, d); chk("R3", "wake after status write", d, 32'h0);
    rd(6'h01, d); chk("R3", "status after write", d, irq_in[63:32]);

    // R4 all masked: no requests
    irq_in = '1;
    @(negedge clk); @(negedge clk);
    chk("R4", "masked lvl_req", 32'(lvl_req), 32'h0);
    check_outs("R4", irq_in);

    // R8 wake ignores mask
    wr(6'h11, 32'h0000_0100);
    irq_in = '0;
    irq_in[40] = 1'b1;
    @(negedge clk);
    chk("R8", "wake while masked", 32'(wake_out), 32'h1);
    chk("R8", "no level while masked", 32'(lvl_req), 32'h0);
    wr(6'h11, 32'h0);
    @(negedge clk);
    chk("R8", "wake cleared", 32'(wake_out), 32'h0);

    // R5/R6/R7 exhaustive: every source against every field value
    for (int b = 0; b < NB; b++) wr(6'(8 + b), 32'hFFFF_FFFF);
    for (int k = 0; k < NA; k++) wr(6'(32 + k), 32'hFFFF_FFFF);
    for (int s = 0; s < NS; s++) begin
      irq_in = '0;
      irq_in[s] = 1'b1;
      for (int v = 0; v < 16; v++) begin
        wr(6'(32 + s / 8), ~(32'hF << ((s % 8) * 4)) | (32'(v) << ((s % 8) * 4)));
        @(negedge clk);
        check_outs(v < NL ? "R5" : "R6", irq_in);
      end
      wr(6'(32 + s / 8), 32'hFFFF_FFFF);
    end

    // R7 lowest source wins within a level
    for (int k = 0; k < NA; k++) wr(6'(32 + k), 32'h3333_3333);
    irq_in = '0;
    irq_in[70] = 1'b1;
    irq_in[40] = 1'b1;
    @(negedge clk);
    chk("R7", "lowest of 40,70", 32'(lvl_src[3*SW +: SW]), 32'd40);
    irq_in[40] = 1'b0;
    @(negedge clk);
    chk("R7", "only 70", 32'(lvl_src[3*SW +: SW]), 32'd70);
    irq_in[0]  = 1'b1;
    irq_in[95] = 1'b1;
    @(negedge clk);
    chk("R7", "lowest of 0,70,95", 32'(lvl_src[3*SW +: SW]), 32'd0);
    wr(6'h08, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R7", "masked 0 skipped", 32'(lvl_src[3*SW +: SW]), 32'd70);
    check_outs("R7", irq_in);

    // R9 one-cycle latency
    prev_irq = irq_in;
    @(negedge clk);
    irq_in = '0;
    irq_in[5] = 1'b1;
    #1;
    chk("R9", "before edge", 32'(lvl_req), 32'h8);
    check_outs("R9", prev_irq);
    @(negedge clk);
    check_outs("R9", irq_in);

    // R4-R8 random configurations
    for (int it = 0; it < 150; it++) begin
      for (int b = 0; b < NB; b++) begin
        wr(6'(8 + b), $urandom);
        wr(6'(16 + b), $urandom & $urandom & $urandom);
      end
      for (int k = 0; k < NA; k++) wr(6'(32 + k), $urandom);
      irq_in = {$urandom, $urandom, $urandom};
      @(negedge clk);
      check_outs("R7", irq_in);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule